// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-bus master that a host uses to reach the configuration registers of Ethernet PHYs and their manageable devices. It produces the management clock and drives or releases the shared data line. It serves two framing styles: the original style with 5-bit register addresses, and the extended style that names a device and reaches a 16-bit register space in two steps. The extended style first sends an address cycle and then sends a data cycle.

The host programs four 32-bit registers through a simple write strobe and reads them back through a combinational read port. One register sets the clock divider, the preamble enable and the framing style. A second register holds the operation and the two address fields; writing it launches a frame. A third register holds outgoing data, which is also the register address carried by extended-style address cycles, together with a busy flag. The fourth register returns the read data with busy and valid flags. The block builds the frame, shifts it out on the data line, releases the line for the turnaround on reads, samples the returned bits and reports whether the responding device answered correctly.

Top module: `mdio_master`

## Requirements
- R1: After reset, the clock register reads divider 4, preamble off and original framing. The command, outgoing-data and read-data registers read 0. `mdc` is low and `mdio_oe` is low.
- R2: During a frame `mdc` toggles every DIV+1 system clocks, where DIV is the clock register field [7:0]. Between frames `mdc` stays low.
- R3: While a frame is in progress, every register write is ignored: no register changes and no second frame starts.
- R4: In original framing (clock register bit 9 = 0) the driven bit sequence is as follows, MSB first: start 01; opcode 01 for operation 0 (write) or 10 for operation 1 (read); the 5-bit PHY address (command [9:5]); the 5-bit register address (command [4:0]); turnaround 10; and, for writes, the 16 outgoing data bits (outgoing-data register [15:0]). The operation is command [11:10], and only its low bit counts in this framing.
- R5: When the preamble enable (clock register bit 8) is 1, 32 one-bits precede the start code. When it is 0, the frame begins directly with the start code.
- R6: In extended framing (clock register bit 9 = 1) the start code is 00 and the 2-bit opcode equals the operation field: 0 is an address cycle, 1 is a write, 2 is a read with post-increment and 3 is a read. The register-address field carries the device address. Address and write cycles send the outgoing-data register as the 16 data bits.
- R7: Each bit is placed on `mdio_o` while `mdc` is low and held across the rising edge. On reads the line is released (`mdio_oe` low) from the first turnaround bit to the end of the frame. Returned data is sampled on rising `mdc` edges, MSB first.
- R8: For write and address cycles, outgoing-data register bit 16 is 1 from the command write until the frame ends. For reads, read-data register bit 17 is 1 for the same span. Each of these busy bits is clear at all other times.
- R9: At the end of a read, the read-data register holds the 16 sampled bits in [15:0]. Its valid bit 16 is 1 only if the second turnaround bit sampled from the line was 0. A new read clears the valid bit when it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write offset: 0 clock, 1 command, 2 outgoing data, 3 read data |
| reg_wdata | input | 32 | Write value |
| reg_raddr | input | 2 | Read offset, same map |
| reg_rdata | output | 32 | Read value for reg_raddr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value as seen on the pin |

## Verification
The assertions assume that the host never expects a register write to land while a frame is busy. They also assume that `mdio_i` matters only while the line is released. Under those assumptions, the busy flags are mutually exclusive, the clock stays low and the line is undriven when idle, and the divider is frozen during a frame. The bench waits for the busy flags to clear before it reprograms the block. The one exception is a deliberate case that writes into a busy frame and checks that the write has no effect. A responder in the bench drives the line only after the master has released it, and uses a good or bad turnaround bit chosen per read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int OP_W      = 2;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 2 + OP_W + 2 * ADDR_W + 2;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int TOTAL_BITS = PRE_BITS + FRAME_BITS;

    localparam logic [1:0] OFS_CLK  = 2'd0;
    localparam logic [1:0] OFS_CMD  = 2'd1;
    localparam logic [1:0] OFS_WDAT = 2'd2;
    localparam logic [1:0] OFS_RDAT = 2'd3;

    localparam int CLK_PRE_BIT  = 8;
    localparam int CLK_MODE_BIT = 9;
    localparam int CMD_DEV_LSB  = 0;
    localparam int CMD_PHY_LSB  = 5;
    localparam int CMD_OP_LSB   = 10;
    localparam int WDAT_BUSY_BIT = 16;
    localparam int RDAT_OK_BIT   = 16;
    localparam int RDAT_BUSY_BIT = 17;

    typedef enum logic { STYLE_SHORT = 1'b0, STYLE_EXT = 1'b1 } frame_style_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] dev;
    } mgmt_cmd_t;

    function automatic logic [OP_W-1:0] line_opcode(frame_style_e s, logic [OP_W-1:0] op);
        if (s == STYLE_EXT) return op;
        return op[0] ? 2'b10 : 2'b01;
    endfunction

    function automatic logic op_reads(frame_style_e s, logic [OP_W-1:0] op);
        return (s == STYLE_EXT) ? op[1] : op[0];
    endfunction

    function automatic logic [FRAME_BITS-1:0] make_frame(frame_style_e s, mgmt_cmd_t c,
                                                        logic [DATA_W-1:0] d);
        logic [1:0] st;
        st = (s == STYLE_EXT) ? 2'b00 : 2'b01;
        return {st, line_opcode(s, c.op), c.phy, c.dev, 2'b10, d};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    assign tick = en && (cnt_q == div);
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_bit_engine.sv
module mdio_bit_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  use_pre,
    input  logic                  is_read,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  ta_ok
);
    localparam int POS_W   = $clog2(TOTAL_BITS);
    localparam int LAST    = TOTAL_BITS - 1;
    localparam int TA_FIRST = PRE_BITS + HDR_BITS - 2;
    localparam int TA_SECOND = TA_FIRST + 1;
    localparam int DATA_FIRST = PRE_BITS + HDR_BITS;

    logic [POS_W-1:0]      pos_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic                  busy_q, rd_q, done_q, ta_q;
    logic [DATA_W-1:0]     shift_q;
    logic                  cur_bit;

    always_comb begin
        int idx;
        idx = LAST - int'(pos_q);
        if (int'(pos_q) < PRE_BITS) cur_bit = 1'b1;
        else                        cur_bit = frame_q[idx];
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rd_data = shift_q;
    assign ta_ok   = ta_q;
    assign mdio_o  = busy_q ? cur_bit : 1'b1;
    assign mdio_oe = busy_q && !(rd_q && int'(pos_q) >= TA_FIRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            frame_q <= '0;
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            ta_q    <= 1'b0;
            shift_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q  <= 1'b1;
                frame_q <= frame;
                rd_q    <= is_read;
                ta_q    <= 1'b0;
                pos_q   <= use_pre ? '0 : POS_W'(PRE_BITS);
            end else if (busy_q) begin
                if (rise && rd_q) begin
                    if (int'(pos_q) == TA_SECOND) ta_q <= !mdio_i;
                    if (int'(pos_q) >= DATA_FIRST) shift_q <= {shift_q[DATA_W-2:0], mdio_i};
                end
                if (fall) begin
                    if (int'(pos_q) == LAST) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int RST_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0]  div_q;
    logic              pre_q;
    frame_style_e      style_q;
    mgmt_cmd_t         cmd_q, new_cmd;
    logic [DATA_W-1:0] wdat_q, rdat_q;
    logic              wpend_q, rpend_q, rvalid_q;

    logic              busy, wr_ok, start, new_rd;
    logic [FRAME_BITS-1:0] frame;
    logic              eng_busy, eng_done, eng_ta_ok, rise, fall;
    logic [DATA_W-1:0] eng_data;

    assign busy  = wpend_q || rpend_q;
    assign wr_ok = reg_we && !busy;
    assign start = wr_ok && (reg_addr == OFS_CMD);

    assign new_cmd = '{op:  reg_wdata[CMD_OP_LSB +: OP_W],
                       phy: reg_wdata[CMD_PHY_LSB +: ADDR_W],
                       dev: reg_wdata[CMD_DEV_LSB +: ADDR_W]};
    assign new_rd  = op_reads(style_q, new_cmd.op);
    assign frame   = make_frame(style_q, new_cmd, wdat_q);

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .en   (eng_busy),
        .div  (div_q),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_bit_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .frame   (frame),
        .use_pre (pre_q),
        .is_read (new_rd),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (eng_busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (eng_done),
        .rd_data (eng_data),
        .ta_ok   (eng_ta_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q    <= DIV_W'(RST_DIV);
            pre_q    <= 1'b0;
            style_q  <= STYLE_SHORT;
            cmd_q    <= '0;
            wdat_q   <= '0;
            rdat_q   <= '0;
            wpend_q  <= 1'b0;
            rpend_q  <= 1'b0;
            rvalid_q <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    OFS_CLK: begin
                        div_q   <= reg_wdata[DIV_W-1:0];
                        pre_q   <= reg_wdata[CLK_PRE_BIT];
                        style_q <= frame_style_e'(reg_wdata[CLK_MODE_BIT]);
                    end
                    OFS_CMD: begin
                        cmd_q <= new_cmd;
                        if (new_rd) begin
                            rpend_q  <= 1'b1;
                            rvalid_q <= 1'b0;
                        end else begin
                            wpend_q <= 1'b1;
                        end
                    end
                    OFS_WDAT: wdat_q <= reg_wdata[DATA_W-1:0];
                    default: ;
                endcase
            end
            if (eng_done) begin
                wpend_q <= 1'b0;
                if (rpend_q) begin
                    rpend_q  <= 1'b0;
                    rdat_q   <= eng_data;
                    rvalid_q <= eng_ta_ok;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            OFS_CLK: begin
                reg_rdata[DIV_W-1:0]    = div_q;
                reg_rdata[CLK_PRE_BIT]  = pre_q;
                reg_rdata[CLK_MODE_BIT] = style_q;
            end
            OFS_CMD: begin
                reg_rdata[CMD_OP_LSB +: OP_W]    = cmd_q.op;
                reg_rdata[CMD_PHY_LSB +: ADDR_W] = cmd_q.phy;
                reg_rdata[CMD_DEV_LSB +: ADDR_W] = cmd_q.dev;
            end
            OFS_WDAT: begin
                reg_rdata[DATA_W-1:0]    = wdat_q;
                reg_rdata[WDAT_BUSY_BIT] = wpend_q;
            end
            default: begin
                reg_rdata[DATA_W-1:0]    = rdat_q;
                reg_rdata[RDAT_OK_BIT]   = rvalid_q;
                reg_rdata[RDAT_BUSY_BIT] = rpend_q;
            end
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wpend,
    input logic             rpend,
    input logic             rvalid,
    input logic             mdc,
    input logic             mdio_oe,
    input logic [DIV_W-1:0] div_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!mdc && !mdio_oe && !wpend && !rpend));

    // R2
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(wpend || rpend) |-> !mdc);

    // R3
    div_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ((wpend || rpend) && $past(wpend || rpend)) |-> $stable(div_q));

    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wpend, rpend}));

    // R8
    drive_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> (wpend || rpend));

    // R9
    valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rpend |-> !rvalid);
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wpend   (wpend_q),
    .rpend   (rpend_q),
    .rvalid  (rvalid_q),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .div_q   (div_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    logic        phy_oe = 1'b0;
    logic        phy_val = 1'b1;
    logic        rsp_arm = 1'b0;
    logic        rsp_bad = 1'b0;
    logic [15:0] rsp_data = '0;
    int          rsp_k = 0;

    logic [63:0] cap = '0;
    int          cap_n = 0;
    logic        mdc_prev = 1'b0;
    int          hp_since = 0;
    int          hp_seen = 0;
    int          hp_bad = 0;
    int          hp_exp = 5;

    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;

    always #4 clk = !clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

    mdio_master u_mdio_master (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Device model: answers reads after the master releases the line
    always @(posedge mdc) begin
        if (rsp_arm && !mdio_oe) begin
            if (rsp_k == 0) begin
                phy_oe  <= 1'b1;
                phy_val <= rsp_bad;
                rsp_k = 1;
            end else if (rsp_k <= 16) begin
                phy_val <= rsp_data[16 - rsp_k];
                rsp_k = rsp_k + 1;
            end else begin
                phy_oe <= 1'b0;
                rsp_k = 0;
            end
        end
    end

    always @(posedge mdc) begin
        if (mdio_oe) begin
            cap   = {cap[62:0], mdio_o};
            cap_n = cap_n + 1;
        end
    end

    always @(posedge clk) begin
        if (mdc != mdc_prev) begin
            if (hp_seen != 0 && hp_since != hp_exp) hp_bad = hp_bad + 1;
            hp_seen  = 1;
            hp_since = 1;
        end else begin
            hp_since = hp_since + 1;
        end
        mdc_prev = mdc;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] exp_frame(input bit ext, input logic [1:0] op,
                                              input logic [4:0] phy, input logic [4:0] dv,
                                              input logic [15:0] d);
        logic [1:0] st, opc;
        st  = ext ? 2'b00 : 2'b01;
        opc = ext ? op : (op[0] ? 2'b10 : 2'b01);
        return {st, opc, phy, dv, 2'b10, d};
    endfunction

    function automatic bit is_rd(input bit ext, input logic [1:0] op);
        return ext ? op[1] : op[0];
    endfunction

    task automatic wait_idle();
        logic [31:0] w, r;
        int n;
        n = 0;
        forever begin
            @(negedge clk);
            rd(2'd2, w);
            rd(2'd3, r);
            if (!w[16] && !r[17]) break;
            n++;
            if (n > 20000) begin
                check(1'b0, "R8 frame never completed", n, 0);
                break;
            end
        end
    endtask

    task automatic txn(input bit ext, input bit pre, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] dv,
                       input logic [15:0] wd, input logic [15:0] pd,
                       input bit bad, input logic [7:0] dvd, input bit poke);
        logic [31:0] v, fr;
        logic [63:0] full, expv, mask;
        int nbits;
        bit rdop;
        rdop = is_rd(ext, op);
        wr(2'd0, {22'd0, ext, pre, dvd});
        wr(2'd2, {16'd0, wd});
        cap_n = 0; cap = '0;
        hp_seen = 0; hp_bad = 0; hp_exp = int'(dvd) + 1;
        rsp_arm = rdop; rsp_bad = bad; rsp_data = pd; rsp_k = 0;
        wr(2'd1, {20'd0, op, phy, dv});
        if (rdop) begin
            rd(2'd3, v);
            check(v[17] == 1'b1 && v[16] == 1'b0, "R8/R9 read busy, valid cleared", v[17:16], 2'b10);
        end else begin
            rd(2'd2, v);
            check(v[16] == 1'b1, "R8 write busy", v[16], 1);
        end
        if (poke) begin
            wr(2'd2, 32'h0000_BEEF);
            wr(2'd0, 32'h0000_0007);
            wr(2'd1, 32'h0000_0C21);
        end
        wait_idle();
        rsp_arm = 1'b0;
        fr    = exp_frame(ext, op, phy, dv, wd);
        full  = {pre ? 32'hFFFF_FFFF : 32'h0, fr};
        nbits = (pre ? 32 : 0) + (rdop ? 14 : 32);
        expv  = rdop ? (full >> 18) : full;
        mask  = (64'd1 << nbits) - 64'd1;
        if (!pre || rdop) expv = expv & mask;
        check(cap_n == nbits, rdop ? "R7 driven bit count on read" : "R5 driven bit count", cap_n, nbits);
        check((cap & mask) == expv, ext ? "R6 extended frame bits" : "R4 short frame bits",
              cap & mask, expv);
        check(hp_bad == 0, "R2 mdc half period", hp_bad, 0);
        #1;
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R2 mdc low and line released when idle",
              {mdc, mdio_oe}, 0);
        if (rdop) begin
            rd(2'd3, v);
            check(v[16:0] == {!bad, pd}, "R9 read data and valid", v[16:0], {!bad, pd});
        end else begin
            rd(2'd2, v);
            check(v[16:0] == {1'b0, wd}, "R8 write busy cleared, data kept", v[16:0], {1'b0, wd});
        end
        if (poke) begin
            rd(2'd0, v);
            check(v[9:0] == {ext, pre, dvd}, "R3 clock register write ignored while busy",
                  v[9:0], {ext, pre, dvd});
            rd(2'd1, v);
            check(v[11:0] == {op, phy, dv}, "R3 command write ignored while busy",
                  v[11:0], {op, phy, dv});
            rd(2'd3, v);
            check(v[17] == 1'b0, "R3 no second frame started", v[17], 0);
        end
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, v); check(v == 32'd4, "R1 clock register reset", v, 4);
        rd(2'd1, v); check(v == 32'd0, "R1 command reset", v, 0);
        rd(2'd2, v); check(v == 32'd0, "R1 outgoing data reset", v, 0);
        rd(2'd3, v); check(v == 32'd0, "R1 read data reset", v, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus idle after reset", {mdc, mdio_oe}, 0);

        // R4 short write and read, with preamble (R5)
        txn(0, 1, 2'd0, 5'h11, 5'h04, 16'h1234, 16'h0, 0, 8'd1, 0);
        txn(0, 1, 2'd1, 5'h1F, 5'h02, 16'h0, 16'hA5C3, 0, 8'd2, 0);
        // R9 bad turnaround
        txn(0, 1, 2'd1, 5'h01, 5'h03, 16'h0, 16'h5A5A, 1, 8'd0, 0);
        // R5 no preamble
        txn(0, 0, 2'd0, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 0, 8'd0, 0);
        txn(0, 0, 2'd1, 5'h0A, 5'h00, 16'h0, 16'h0001, 0, 8'd3, 0);
        // R6 extended: address, write, read-increment, read
        txn(1, 1, 2'd0, 5'h03, 5'd1, 16'h0102, 16'h0, 0, 8'd1, 0);
        txn(1, 1, 2'd1, 5'h03, 5'd1, 16'hCAFE, 16'h0, 0, 8'd1, 0);
        txn(1, 0, 2'd2, 5'h03, 5'd30, 16'h0, 16'h8001, 0, 8'd0, 0);
        txn(1, 1, 2'd3, 5'h07, 5'd29, 16'h0, 16'h7FFE, 0, 8'd2, 0);
        // R3 writes during a busy frame
        txn(0, 0, 2'd0, 5'h05, 5'h06, 16'h4321, 16'h0, 0, 8'd2, 1);
        txn(1, 0, 2'd3, 5'h09, 5'd4, 16'h0, 16'h3C3C, 0, 8'd2, 1);

        for (int i = 0; i < 24; i++) begin
            txn(1'($urandom), 1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom),
                16'($urandom), 16'($urandom), ($urandom % 4) == 0, 8'($urandom % 4), 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule